// File: doc/BRIEF.md
# Parallel Strobe to Serial Byte Bridge

This block sits between a host that hands over bytes with a parallel-port style strobe and an audio decoder that takes its data as a framed serial stream. When the host pulls its strobe low, the bridge waits for the strobe to go high again. It then gives the host a short active-low acknowledge pulse. After that it walks the byte out of an external parallel-in shift register one bit at a time. The host has already loaded that register. The bridge drives the register's shift clock and the decoder's data clock as one pair. A byte-sync output is high for the whole byte.

The decoder asks for more data with a request line. The bridge turns that line into the host's busy flag. A rising request clears busy. After each byte, busy is set again only if the decoder has stopped asking. Both asynchronous inputs, strobe and request, pass through a two-flop synchroniser before their edges are detected. The acknowledge width and the width of each serial clock phase are parameters counted in system clocks.

Top module: `strobe_serial_bridge`

## Requirements
- R1: While reset is asserted, busy and the active-low acknowledge are high, and the data clock, shift clock, byte sync and serial data are low.
- R2: A transfer starts only on a falling edge of the host strobe. While the strobe stays low, no acknowledge pulse is produced.
- R3: After the strobe has returned high, the acknowledge goes low for exactly ACK_W system clocks, once per transfer, and never while byte sync is high.
- R4: Byte sync rises before the first data-clock rising edge and falls together with the eighth falling edge. Each frame holds exactly 8 data-clock rising edges.
- R5: The serial data carries the external shift register output, most significant bit first. It is set while the clocks are low and is stable across each rising edge, so the 8 captured bits equal the byte loaded into the register.
- R6: The shift register clock and the decoder data clock are identical at all times.
- R7: Each high phase, and each low phase between two bits of a frame, lasts exactly PH_W system clocks.
- R8: At the end of a byte, busy is set if the synchronised request is low and is left unchanged if it is high. Busy rises one clock after byte sync falls.
- R9: A rising edge of the request input, seen with the request high, clears busy. A falling request leaves busy unchanged.
- R10: A strobe falling edge that arrives while a transfer is in progress is ignored: it gives no extra acknowledge and no extra frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_n_i | input | 1 | Host strobe, active low, asynchronous |
| dreq_i | input | 1 | Decoder data request, asynchronous |
| sr_q_i | input | 1 | Serial output of the external shift register |
| ack_n_o | output | 1 | Acknowledge to host, active low |
| busy_o | output | 1 | Busy flag to host |
| bsync_o | output | 1 | Byte sync framing the 8 bits |
| sdata_o | output | 1 | Serial data to the decoder |
| sr_clk_o | output | 1 | Shift clock to the external register |
| dclk_o | output | 1 | Data clock to the decoder |

## Verification
An input edge reaches the edge detector on the second clock, and the registered response comes one clock after that. So a request rise clears busy on the third rising edge, and the bench samples busy four falling edges after the change. The acknowledge can fall no earlier than three clocks after the strobe is released. The serial frame runs 8 × 2 × PH_W clocks after the acknowledge, and busy follows byte sync by one clock. The driver therefore waits for byte sync to fall and then lets three falling edges pass before it reads busy. The monitor samples every output on falling clock edges. It measures pulse and phase widths by counting those samples, and it pops an expected byte from the scoreboard whenever byte sync falls.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [2:0] {
        SEQ_IDLE,
        SEQ_WAIT_REL,
        SEQ_ACK,
        SEQ_BIT_LO,
        SEQ_BIT_HI
    } seq_state_e;

    typedef struct packed {
        logic level;
        logic rise;
        logic fall;
    } edge_flags_t;

endpackage

// File: rtl/bridge_sync_edge.sv
module bridge_sync_edge
    import bridge_pkg::*;
#(
    parameter int  STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        async_i,
    output edge_flags_t flags_o
);

    localparam int CHAIN_W = STAGES + 1;

    typedef struct packed {
        logic [CHAIN_W-1:0] chain;
    } sync_t;

    sync_t r_q, r_d;

    always_comb begin
        r_d       = r_q;
        r_d.chain = {r_q.chain[CHAIN_W-2:0], async_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.chain <= {CHAIN_W{RST_VAL}};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        flags_o.level = r_q.chain[STAGES-1];
        flags_o.rise  = r_q.chain[STAGES-1] & ~r_q.chain[STAGES];
        flags_o.fall  = ~r_q.chain[STAGES-1] & r_q.chain[STAGES];
    end

endmodule

// File: rtl/bridge_shift_seq.sv
module bridge_shift_seq
    import bridge_pkg::*;
#(
    parameter int ACK_W = 4,
    parameter int PH_W  = 3,
    parameter int BITS  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  edge_flags_t strobe_i,
    input  logic        sr_q_i,
    output logic        ack_n_o,
    output logic        bsync_o,
    output logic        sdata_o,
    output logic        sclk_o,
    output logic        done_o
);

    localparam int MAX_W = (ACK_W > PH_W) ? ACK_W : PH_W;
    localparam int CNT_W = $clog2(MAX_W + 1);
    localparam int BIT_W = (BITS > 1) ? $clog2(BITS) : 1;
    localparam logic [CNT_W-1:0] ACK_LOAD = CNT_W'(ACK_W - 1);
    localparam logic [CNT_W-1:0] PH_LOAD  = CNT_W'(PH_W - 1);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BITS - 1);

    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic [BIT_W-1:0] bitn;
        logic             ack_n;
        logic             bsync;
        logic             sdata;
        logic             sclk;
        logic             done;
    } seq_t;

    seq_t r_q, r_d;

    logic cnt_zero;
    assign cnt_zero = (r_q.cnt == '0);

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            SEQ_IDLE: begin
                if (strobe_i.fall) begin
                    r_d.state = SEQ_WAIT_REL;
                end
            end
            SEQ_WAIT_REL: begin
                if (strobe_i.level) begin
                    r_d.state = SEQ_ACK;
                    r_d.ack_n = 1'b0;
                    r_d.cnt   = ACK_LOAD;
                end
            end
            SEQ_ACK: begin
                if (cnt_zero) begin
                    r_d.state = SEQ_BIT_LO;
                    r_d.ack_n = 1'b1;
                    r_d.bsync = 1'b1;
                    r_d.sdata = sr_q_i;
                    r_d.bitn  = '0;
                    r_d.cnt   = PH_LOAD;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            SEQ_BIT_LO: begin
                if (cnt_zero) begin
                    r_d.state = SEQ_BIT_HI;
                    r_d.sclk  = 1'b1;
                    r_d.cnt   = PH_LOAD;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            SEQ_BIT_HI: begin
                if (cnt_zero) begin
                    r_d.sclk = 1'b0;
                    if (r_q.bitn == LAST_BIT) begin
                        r_d.state = SEQ_IDLE;
                        r_d.bsync = 1'b0;
                        r_d.done  = 1'b1;
                    end else begin
                        r_d.state = SEQ_BIT_LO;
                        r_d.bitn  = r_q.bitn + 1'b1;
                        r_d.sdata = sr_q_i;
                        r_d.cnt   = PH_LOAD;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            default: begin
                r_d.state = SEQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state <= SEQ_IDLE;
            r_q.cnt   <= '0;
            r_q.bitn  <= '0;
            r_q.ack_n <= 1'b1;
            r_q.bsync <= 1'b0;
            r_q.sdata <= 1'b0;
            r_q.sclk  <= 1'b0;
            r_q.done  <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign ack_n_o = r_q.ack_n;
    assign bsync_o = r_q.bsync;
    assign sdata_o = r_q.sdata;
    assign sclk_o  = r_q.sclk;
    assign done_o  = r_q.done;

endmodule

// File: rtl/bridge_busy.sv
module bridge_busy
    import bridge_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  edge_flags_t dreq_i,
    input  logic        done_i,
    output logic        busy_o
);

    typedef struct packed {
        logic busy;
    } busy_t;

    busy_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        if (dreq_i.rise && dreq_i.level) begin
            r_d.busy = 1'b0;
        end else if (done_i && !dreq_i.level) begin
            r_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.busy <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy_o = r_q.busy;

endmodule

// File: rtl/strobe_serial_bridge.sv
module strobe_serial_bridge
    import bridge_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ACK_W       = 4,
    parameter int PH_W        = 3,
    parameter int BITS        = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe_n_i,
    input  logic dreq_i,
    input  logic sr_q_i,
    output logic ack_n_o,
    output logic busy_o,
    output logic bsync_o,
    output logic sdata_o,
    output logic sr_clk_o,
    output logic dclk_o
);

    edge_flags_t strobe_flags;
    edge_flags_t dreq_flags;
    logic        shift_clk;
    logic        byte_done;

    bridge_sync_edge #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) u_strobe_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (strobe_n_i),
        .flags_o (strobe_flags)
    );

    bridge_sync_edge #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b0)
    ) u_dreq_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (dreq_i),
        .flags_o (dreq_flags)
    );

    bridge_shift_seq #(
        .ACK_W (ACK_W),
        .PH_W  (PH_W),
        .BITS  (BITS)
    ) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe_i (strobe_flags),
        .sr_q_i   (sr_q_i),
        .ack_n_o  (ack_n_o),
        .bsync_o  (bsync_o),
        .sdata_o  (sdata_o),
        .sclk_o   (shift_clk),
        .done_o   (byte_done)
    );

    bridge_busy u_busy (
        .clk    (clk),
        .rst_n  (rst_n),
        .dreq_i (dreq_flags),
        .done_i (byte_done),
        .busy_o (busy_o)
    );

    assign sr_clk_o = shift_clk;
    assign dclk_o   = shift_clk;

endmodule

// File: rtl/bridge_checker.sv
module bridge_checker #(
    parameter int ACK_W = 4
) (
    input logic clk,
    input logic rst_n,
    input logic ack_n_o,
    input logic busy_o,
    input logic bsync_o,
    input logic sdata_o,
    input logic sr_clk_o,
    input logic dclk_o
);

    int unsigned ack_lo_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_lo_cnt <= 0;
        end else if (!ack_n_o) begin
            ack_lo_cnt <= ack_lo_cnt + 1;
        end else begin
            ack_lo_cnt <= 0;
        end
    end

    AST_CLK_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |-> bsync_o); // R4

    AST_CLK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        sr_clk_o == dclk_o); // R6

    AST_DATA_STABLE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dclk_o) |-> $stable(sdata_o)); // R5

    AST_ACK_OUT_OF_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_n_o |-> !bsync_o); // R3

    AST_ACK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_n_o) |-> (ack_lo_cnt == ACK_W)); // R3

    AST_BUSY_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> ($past(bsync_o, 2) && !$past(bsync_o))); // R8

endmodule

bind strobe_serial_bridge bridge_checker #(.ACK_W(ACK_W)) u_bridge_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .ack_n_o  (ack_n_o),
    .busy_o   (busy_o),
    .bsync_o  (bsync_o),
    .sdata_o  (sdata_o),
    .sr_clk_o (sr_clk_o),
    .dclk_o   (dclk_o)
);

// File: tb/strobe_serial_bridge_bench.sv
module strobe_serial_bridge_bench;

    localparam int ACK_W = 4;
    localparam int PH_W  = 3;

    logic clk = 1'b0;
    logic rst_n;
    logic strobe_n_i;
    logic dreq_i;
    logic sr_q_i;
    logic ack_n_o, busy_o, bsync_o, sdata_o, sr_clk_o, dclk_o;

    always #2.5 clk = ~clk;

    strobe_serial_bridge #(
        .ACK_W (ACK_W),
        .PH_W  (PH_W)
    ) u_strobe_serial_bridge (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe_n_i (strobe_n_i),
        .dreq_i     (dreq_i),
        .sr_q_i     (sr_q_i),
        .ack_n_o    (ack_n_o),
        .busy_o     (busy_o),
        .bsync_o    (bsync_o),
        .sdata_o    (sdata_o),
        .sr_clk_o   (sr_clk_o),
        .dclk_o     (dclk_o)
    );

    int n_chk  = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // external parallel-in shift register model, MSB out first
    logic [7:0] sr_model;
    logic [7:0] load_val;
    logic       load_stb = 1'b0;
    always @(posedge sr_clk_o or posedge load_stb) begin
        if (load_stb) sr_model <= load_val;
        else          sr_model <= {sr_model[6:0], 1'b0};
    end
    assign sr_q_i = sr_model[7];

    // scoreboard
    logic [7:0] exp_q[$];
    int ack_pulses = 0;
    int clk_mismatch = 0;

    // monitor
    logic       p_dclk = 1'b0, p_bsync = 1'b0, p_ack = 1'b1;
    logic [7:0] cap;
    int n_rise, hi_w, lo_w, ack_w;
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (sr_clk_o !== dclk_o) clk_mismatch++;
            if (bsync_o && !p_bsync) begin
                n_rise = 0;
                cap    = 8'h00;
                lo_w   = 0;
            end
            if (dclk_o && !p_dclk) begin
                cap = {cap[6:0], sdata_o};
                n_rise++;
                hi_w = 1;
                if (n_rise > 1) check(lo_w == PH_W, "R7 low phase", lo_w, PH_W);
            end else if (dclk_o) begin
                hi_w++;
            end
            if (!dclk_o && p_dclk) begin
                check(hi_w == PH_W, "R7 high phase", hi_w, PH_W);
                lo_w = 1;
            end else if (!dclk_o && bsync_o) begin
                lo_w++;
            end
            if (!bsync_o && p_bsync) begin
                check(n_rise == 8, "R4 clock count", n_rise, 8);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R5 unexpected frame", cap, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(cap == e, "R5 byte", cap, e);
                end
            end
            if (!ack_n_o && p_ack) begin
                ack_pulses++;
                ack_w = 1;
                check(strobe_n_i == 1'b1, "R3 ack after release", strobe_n_i, 1);
            end else if (!ack_n_o) begin
                ack_w++;
            end
            if (ack_n_o && !p_ack) check(ack_w == ACK_W, "R3 ack width", ack_w, ACK_W);
            p_dclk  = dclk_o;
            p_bsync = bsync_o;
            p_ack   = ack_n_o;
        end
    end

    task automatic send_byte(input logic [7:0] b, input bit glitch, input bit exp_busy, input string req);
        int acks0;
        acks0 = ack_pulses;
        @(negedge clk);
        load_val = b;
        load_stb = 1'b1;
        @(negedge clk);
        load_stb = 1'b0;
        exp_q.push_back(b);
        strobe_n_i = 1'b0;
        repeat (8) @(negedge clk);
        check(ack_n_o == 1'b1, "R2 no ack while strobe low", ack_n_o, 1);
        strobe_n_i = 1'b1;
        if (glitch) begin
            @(posedge bsync_o);
            repeat (5) @(negedge clk);
            strobe_n_i = 1'b0;          // R10 strobe fall mid-transfer
            repeat (4) @(negedge clk);
            strobe_n_i = 1'b1;
        end
        @(negedge bsync_o);
        repeat (3) @(negedge clk);
        check(busy_o == exp_busy, req, busy_o, exp_busy);
        repeat (20) @(negedge clk);
        check(ack_pulses == acks0 + 1, glitch ? "R10 single ack" : "R3 single ack",
              ack_pulses - acks0, 1);
        check(bsync_o == 1'b0, glitch ? "R10 no extra frame" : "R4 frame closed", bsync_o, 0);
    endtask

    initial begin
        rst_n      = 1'b0;
        strobe_n_i = 1'b1;
        dreq_i     = 1'b0;
        load_val   = 8'h00;
        repeat (3) @(negedge clk);
        check(busy_o   == 1'b1, "R1 busy", busy_o, 1);
        check(ack_n_o  == 1'b1, "R1 ack", ack_n_o, 1);
        check(dclk_o   == 1'b0, "R1 dclk", dclk_o, 0);
        check(sr_clk_o == 1'b0, "R1 sr_clk", sr_clk_o, 0);
        check(bsync_o  == 1'b0, "R1 bsync", bsync_o, 0);
        check(sdata_o  == 1'b0, "R1 sdata", sdata_o, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        dreq_i = 1'b1;
        repeat (4) @(negedge clk);
        check(busy_o == 1'b0, "R9 request rise clears busy", busy_o, 0);
        dreq_i = 1'b0;
        repeat (6) @(negedge clk);
        check(busy_o == 1'b0, "R9 request fall no effect", busy_o, 0);

        send_byte(8'hA5, 1'b0, 1'b1, "R8 busy set, request low");
        send_byte(8'h3C, 1'b0, 1'b1, "R8 busy stays set");
        dreq_i = 1'b1;
        repeat (4) @(negedge clk);
        check(busy_o == 1'b0, "R9 clear again", busy_o, 0);
        send_byte(8'h81, 1'b0, 1'b0, "R8 busy kept low, request high");
        send_byte(8'h5E, 1'b1, 1'b0, "R8 busy low after glitch byte");
        dreq_i = 1'b0;
        send_byte(8'hFF, 1'b0, 1'b1, "R8 busy set, all ones");
        send_byte(8'h00, 1'b0, 1'b1, "R8 busy set, all zeros");

        check(clk_mismatch == 0, "R6 clock pair", clk_mismatch, 0);
        check(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule